// File: doc/BRIEF.md
# Double-Precision Floating-Point Multiplier

This block multiplies two floating-point operands and always produces a double-precision (64-bit) result. A precision-select input says whether the two operands arrive as double values or as single values in the low 32 bits of each operand input. Single operands are widened to double format at the input. From that point on, one shared double datapath forms the sign, the biased exponent, the 106-bit significand product, the guard, round and sticky bits, the normalized significand and the rounded result.

A client drives the operands, the precision select and a 2-bit rounding mode, then raises `start` for one cycle. On the next clock edge the result and five exception flags are captured in output registers, and `done` is high for that one cycle. The outputs hold until the next `start`. Denormal operands are treated as zero. Any NaN operand returns the default quiet NaN.

Top module: `fmul_dp`

## Requirements
- R1: When `prec_sp` is 1, each operand is taken from bits [31:0] as a single value. A nonzero biased exponent that is not 255 is rebiased by adding 896. The 23-bit fraction is placed in the top of the 52-bit fraction. When `prec_sp` is 0, bits [63:0] are a double value. The result is always a double.
- R2: The result sign is the XOR of the two operand signs. This applies to finite, zero and infinite results.
- R3: For finite nonzero operands, the result biased exponent is the sum of the operand biased exponents minus 1023. The 106-bit significand product is shifted right by one when its top bit is set, and the exponent is then increased by one. Product bits below the guard and round bits are ORed into a sticky bit.
- R4: `rnd_mode` encodings: 00 is round to nearest even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity. If the rounding increment carries out of the 53-bit significand, the significand becomes 1.0 and the exponent is increased by one.
- R5: Special operands. A NaN operand (exponent all ones, nonzero fraction) returns 0x7FF8000000000000 with no flags. Infinity times zero returns 0x7FF8000000000000 with the invalid flag set. Infinity times a nonzero value returns a signed infinity with no flags. An operand whose exponent field is 0 counts as zero, so zero times a finite value returns a signed zero with no flags.
- R6: If the exponent after rounding is 2047 or more, the overflow and inexact flags are set. The result is signed infinity in mode 00, and also in mode 10 for a positive result and in mode 11 for a negative result. Otherwise the result is the signed largest finite value (exponent 0x7FE, fraction all ones).
- R7: If the exponent after rounding is below 1, the result is a signed zero and the underflow and inexact flags are set.
- R8: `done` is 1 in exactly the cycle after `start` was sampled high, and 0 otherwise. `result` and `flags` are loaded at that edge and hold until the next start. Reset clears `done`, `result` and `flags` to 0.
- R9: Flag bit positions: `flags[4]` is invalid, `flags[3]` is divide-by-zero (always 0), `flags[2]` is overflow, `flags[1]` is underflow and `flags[0]` is inexact. For an in-range finite result, inexact is set exactly when any discarded product bit is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the current operation at this edge |
| prec_sp | input | 1 | 1: operands are single values in bits [31:0]; 0: double |
| rnd_mode | input | 2 | Rounding mode (see R4) |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| done | output | 1 | One-cycle pulse when a result is loaded |
| result | output | 64 | Double-precision product |
| flags | output | 5 | {invalid, div_zero, overflow, underflow, inexact} |

## Verification
The datapath holds no state between operations except the output register. A fault in widening, exponent arithmetic, normalization or rounding therefore shows up in `result` or `flags` in the cycle when `done` is high, one clock after `start`. Faults in rounding and sticky logic are exposed by random operands under all four modes. They only appear in the low fraction bits or the inexact flag. Faults in the overflow and underflow decisions show up as the wrong special value or wrong flags on the directed extreme-exponent cases.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    localparam int DW    = 64;          // result and operand width
    localparam int EW    = 11;          // double exponent width
    localparam int FW    = 52;          // double fraction width
    localparam int SW    = FW + 1;      // significand with hidden one
    localparam int PW    = 2 * SW;      // significand product width
    localparam int BIAS  = (1 << (EW - 1)) - 1;
    localparam int SEW   = 8;           // single exponent width
    localparam int SFW   = 23;          // single fraction width
    localparam int SBIAS = (1 << (SEW - 1)) - 1;
    localparam int EMAX  = (1 << EW) - 1;
    localparam int FLW   = 5;

    localparam logic [DW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } round_mode_e;

    typedef struct packed {
        logic            sign;
        logic [EW-1:0]   exp;
        logic [SW-1:0]   sig;
        fp_class_e       cls;
    } fp_op_t;

    typedef struct packed {
        logic invalid;
        logic div_zero;
        logic overflow;
        logic underflow;
        logic inexact;
    } fp_flags_t;

    function automatic logic [DW-1:0] pack_inf(input logic s);
        return {s, {EW{1'b1}}, {FW{1'b0}}};
    endfunction

    function automatic logic [DW-1:0] pack_max_finite(input logic s);
        return {s, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
    endfunction

    function automatic logic round_up(input round_mode_e rm, input logic sign,
                                      input logic lsb, input logic g,
                                      input logic r, input logic st);
        case (rm)
            RM_NEAR_EVEN: return g & (r | st | lsb);
            RM_TO_ZERO:   return 1'b0;
            RM_TO_POS:    return ~sign & (g | r | st);
            default:      return sign & (g | r | st);
        endcase
    endfunction

    function automatic logic [DW-1:0] overflow_value(input round_mode_e rm, input logic s);
        logic to_inf;
        to_inf = (rm == RM_NEAR_EVEN) || (rm == RM_TO_POS && !s) || (rm == RM_TO_NEG && s);
        return to_inf ? pack_inf(s) : pack_max_finite(s);
    endfunction

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
    import fmul_pkg::*;
(
    input  logic [DW-1:0] raw,
    input  logic          sp,
    output fp_op_t        op
);
    localparam int SE_LO = SFW;
    localparam int SE_HI = SFW + SEW - 1;
    localparam int SS    = SFW + SEW;
    localparam int DE_LO = FW;
    localparam int DE_HI = FW + EW - 1;
    localparam int PADW  = FW - SFW;

    logic [EW-1:0] exp_w;
    logic [FW-1:0] frac_w;
    logic          sign_w;
    logic          e_zero;
    logic          e_ones;

    always_comb begin
        if (sp) begin
            sign_w = raw[SS];
            exp_w  = EW'(raw[SE_HI:SE_LO]) + EW'(BIAS - SBIAS);
            frac_w = {raw[SFW-1:0], {PADW{1'b0}}};
            e_zero = (raw[SE_HI:SE_LO] == '0);
            e_ones = (&raw[SE_HI:SE_LO]);
        end else begin
            sign_w = raw[DW-1];
            exp_w  = raw[DE_HI:DE_LO];
            frac_w = raw[FW-1:0];
            e_zero = (raw[DE_HI:DE_LO] == '0);
            e_ones = (&raw[DE_HI:DE_LO]);
        end

        op.sign = sign_w;
        op.exp  = exp_w;
        op.sig  = {1'b1, frac_w};
        if (e_zero) begin
            op.cls = CLS_ZERO;
            op.sig = '0;
        end else if (e_ones) begin
            op.cls = (frac_w == '0) ? CLS_INF : CLS_NAN;
        end else begin
            op.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul #(
    parameter int W = 53
) (
    input  logic [W-1:0]   sig_a,
    input  logic [W-1:0]   sig_b,
    output logic [2*W-1:0] prod
);
    assign prod = {{W{1'b0}}, sig_a} * {{W{1'b0}}, sig_b};
endmodule

// File: rtl/fmul_round.sv
module fmul_round
    import fmul_pkg::*;
(
    input  logic          sign_a,
    input  logic          sign_b,
    input  logic [EW-1:0] exp_a,
    input  logic [EW-1:0] exp_b,
    input  fp_class_e     cls_a,
    input  fp_class_e     cls_b,
    input  logic [PW-1:0] prod,
    input  round_mode_e   rm,
    output logic [DW-1:0] res,
    output fp_flags_t     fl
);
    logic          sign;
    logic          shift;
    logic [SW-1:0] mant;
    logic          g_bit, r_bit, st_bit;
    logic          lost;
    logic          inc;
    logic [SW:0]   summed;
    logic [SW-1:0] mant_r;
    int            exp_i;

    always_comb begin
        sign  = sign_a ^ sign_b;
        shift = prod[PW-1];
        if (shift) begin
            mant   = prod[PW-1 -: SW];
            g_bit  = prod[PW-SW-1];
            r_bit  = prod[PW-SW-2];
            st_bit = |prod[PW-SW-3:0];
        end else begin
            mant   = prod[PW-2 -: SW];
            g_bit  = prod[PW-SW-2];
            r_bit  = prod[PW-SW-3];
            st_bit = |prod[PW-SW-4:0];
        end
        lost  = g_bit | r_bit | st_bit;
        exp_i = int'(exp_a) + int'(exp_b) - BIAS + int'(shift);
        inc   = round_up(rm, sign, mant[0], g_bit, r_bit, st_bit);
        summed = {1'b0, mant} + (SW+1)'(inc);
        if (summed[SW]) begin
            mant_r = summed[SW:1];
            exp_i  = exp_i + 1;
        end else begin
            mant_r = summed[SW-1:0];
        end

        fl  = '0;
        res = '0;
        if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
            res = QNAN;
        end else if ((cls_a == CLS_INF && cls_b == CLS_ZERO) ||
                     (cls_a == CLS_ZERO && cls_b == CLS_INF)) begin
            res        = QNAN;
            fl.invalid = 1'b1;
        end else if (cls_a == CLS_INF || cls_b == CLS_INF) begin
            res = pack_inf(sign);
        end else if (cls_a == CLS_ZERO || cls_b == CLS_ZERO) begin
            res = {sign, {(DW-1){1'b0}}};
        end else if (exp_i >= EMAX) begin
            res         = overflow_value(rm, sign);
            fl.overflow = 1'b1;
            fl.inexact  = 1'b1;
        end else if (exp_i < 1) begin
            res          = {sign, {(DW-1){1'b0}}};
            fl.underflow = 1'b1;
            fl.inexact   = 1'b1;
        end else begin
            res        = {sign, exp_i[EW-1:0], mant_r[FW-1:0]};
            fl.inexact = lost;
        end
    end
endmodule

// File: rtl/fmul_dp.sv
module fmul_dp
    import fmul_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           prec_sp,
    input  logic [1:0]     rnd_mode,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    output logic           done,
    output logic [DW-1:0]  result,
    output logic [FLW-1:0] flags
);
    logic [DW-1:0] raw_ops [2];
    fp_op_t        ops     [2];
    logic [PW-1:0] sig_prod;
    logic [DW-1:0] res_c;
    fp_flags_t     fl_c;

    assign raw_ops[0] = op_a;
    assign raw_ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_unpack
        fmul_unpack u_unpack (
            .raw (raw_ops[i]),
            .sp  (prec_sp),
            .op  (ops[i])
        );
    end

    fmul_sigmul #(.W(SW)) u_sigmul (
        .sig_a (ops[0].sig),
        .sig_b (ops[1].sig),
        .prod  (sig_prod)
    );

    fmul_round u_round (
        .sign_a (ops[0].sign),
        .sign_b (ops[1].sign),
        .exp_a  (ops[0].exp),
        .exp_b  (ops[1].exp),
        .cls_a  (ops[0].cls),
        .cls_b  (ops[1].cls),
        .prod   (sig_prod),
        .rm     (round_mode_e'(rnd_mode)),
        .res    (res_c),
        .fl     (fl_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
            flags  <= '0;
        end else begin
            done <= start;
            if (start) begin
                result <= res_c;
                flags  <= fl_c;
            end
        end
    end

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst) start |=> done); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) !start |=> !done); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(result)); // R8
    AST_INVALID_QNAN: assert property (@(posedge clk) disable iff (rst) (done && flags[4]) |-> (result == QNAN)); // R5
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (rst) (done && flags[2]) |-> (flags[0] && !flags[1])); // R6
    AST_UF_SIGNED_ZERO: assert property (@(posedge clk) disable iff (rst) (done && flags[1]) |-> (result[DW-2:0] == '0 && flags[0])); // R7
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
        (start && res_c != QNAN) |=> (result[DW-1] == $past(prec_sp ? (op_a[31] ^ op_b[31]) : (op_a[DW-1] ^ op_b[DW-1])))); // R2
endmodule

// File: tb/fmul_dp_test.sv
`timescale 1ns/1ps
module fmul_dp_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        prec_sp;
    logic [1:0]  rnd_mode;
    logic [63:0] op_a, op_b;
    logic        done;
    logic [63:0] result;
    logic [4:0]  flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000;

    always #2.5 clk = ~clk;

    fmul_dp uut (
        .clk(clk), .rst(rst), .start(start), .prec_sp(prec_sp),
        .rnd_mode(rnd_mode), .op_a(op_a), .op_b(op_b),
        .done(done), .result(result), .flags(flags)
    );

    // kind: 0 zero, 1 normal, 2 infinity, 3 NaN
    function automatic void decode(input logic [63:0] x, input logic sp,
                                   output logic sg, output int ex,
                                   output logic [52:0] m, output int kind);
        int e8;
        m  = '0;
        ex = 0;
        if (sp) begin
            sg = x[31];
            e8 = int'(x[30:23]);
            if (e8 == 0) kind = 0;
            else if (e8 == 255) kind = (x[22:0] != 0) ? 3 : 2;
            else begin
                kind = 1;
                ex   = e8 - 127 + 1023;
                m    = {1'b1, x[22:0], 29'd0};
            end
        end else begin
            sg = x[63];
            e8 = int'(x[62:52]);
            if (e8 == 0) kind = 0;
            else if (e8 == 2047) kind = (x[51:0] != 0) ? 3 : 2;
            else begin
                kind = 1;
                ex   = e8;
                m    = {1'b1, x[51:0]};
            end
        end
    endfunction

    function automatic logic [68:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic sp, input logic [1:0] rm);
        logic sa, sb, s, up, nz, big;
        int ea, eb, ka, kb, e, sh;
        logic [52:0] ma, mb;
        logic [105:0] p, kept, half, rem;
        decode(a, sp, sa, ea, ma, ka);
        decode(b, sp, sb, eb, mb, kb);
        s = sa ^ sb;
        if (ka == 3 || kb == 3) return {5'b00000, QN};
        if ((ka == 2 && kb == 0) || (ka == 0 && kb == 2)) return {5'b10000, QN};
        if (ka == 2 || kb == 2) return {5'b00000, s, 11'h7FF, 52'd0};
        if (ka == 0 || kb == 0) return {5'b00000, s, 63'd0};
        p    = {53'd0, ma} * {53'd0, mb};
        sh   = p[105] ? 1 : 0;
        e    = ea + eb - 1023 + sh;
        kept = p >> (52 + sh);
        half = 106'd1 << (51 + sh);
        rem  = p & ((half << 1) - 106'd1);
        nz   = (rem != 0);
        case (rm)
            2'b00:   up = (rem > half) || (rem == half && kept[0]);
            2'b01:   up = 1'b0;
            2'b10:   up = nz && !s;
            default: up = nz && s;
        endcase
        kept = kept + 106'(up);
        if (kept[53]) begin
            kept = kept >> 1;
            e    = e + 1;
        end
        if (e >= 2047) begin
            big = (rm == 2'b00) || (rm == 2'b10 && !s) || (rm == 2'b11 && s);
            return {5'b00101, big ? {s, 11'h7FF, 52'd0} : {s, 11'h7FE, {52{1'b1}}}};
        end
        if (e < 1) return {5'b00011, s, 63'd0};
        return {4'b0000, nz, s, e[10:0], kept[51:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [63:0] a, input logic [63:0] b,
                          input logic sp, input logic [1:0] rm,
                          input logic [63:0] exp_res, input logic [4:0] exp_fl);
        @(negedge clk);
        op_a = a; op_b = b; prec_sp = sp; rnd_mode = rm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(req, "result", result, exp_res);
        check(req, "flags", {59'd0, flags}, {59'd0, exp_fl});
        check("R8", "done pulse", {63'd0, done}, 64'd1);
    endtask

    task automatic run_model(input string req, input logic [63:0] a, input logic [63:0] b,
                             input logic sp, input logic [1:0] rm);
        logic [68:0] m;
        m = model(a, b, sp, rm);
        run_op(req, a, b, sp, rm, m[63:0], m[68:64]);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        logic [63:0] held;
        logic        rsp;
        logic [1:0]  rrm;
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; prec_sp = 1'b0; rnd_mode = 2'b00; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "reset done", {63'd0, done}, 64'd0);
        check("R8", "reset result", result, 64'd0);
        check("R8", "reset flags", {59'd0, flags}, 64'd0);

        // R3 basic exact products
        run_op("R3", 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b0, 2'b00, 64'h3FF0_0000_0000_0000, 5'b00000);
        run_op("R3", 64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0000, 1'b0, 2'b00, 64'h4002_0000_0000_0000, 5'b00000);
        // R2 sign
        run_op("R2", 64'hC000_0000_0000_0000, 64'h4008_0000_0000_0000, 1'b0, 2'b00, 64'hC018_0000_0000_0000, 5'b00000);
        // R1 single widened: 1.0f * 2.0f, and -1.5f * 1.5f (upper bits ignored)
        run_op("R1", 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, 1'b1, 2'b00, 64'h4000_0000_0000_0000, 5'b00000);
        run_op("R1", 64'h0000_0000_BFC0_0000, 64'h0000_0000_3FC0_0000, 1'b1, 2'b00, 64'hC002_0000_0000_0000, 5'b00000);
        // R4 and R9: (1+ulp)^2 under the modes
        run_op("R4", 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0001, 1'b0, 2'b00, 64'h3FF0_0000_0000_0002, 5'b00001);
        run_op("R4", 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0001, 1'b0, 2'b01, 64'h3FF0_0000_0000_0002, 5'b00001);
        run_op("R4", 64'h3FF0_0000_0000_0001, 64'h3FF0_0000_0000_0001, 1'b0, 2'b10, 64'h3FF0_0000_0000_0003, 5'b00001);
        run_op("R9", 64'hBFF0_0000_0000_0001, 64'h3FF0_0000_0000_0001, 1'b0, 2'b11, 64'hBFF0_0000_0000_0003, 5'b00001);
        run_op("R4", 64'h3FFF_FFFF_FFFF_FFFF, 64'h3FF0_0000_0000_0001, 1'b0, 2'b10, 64'h4000_0000_0000_0001, 5'b00001);
        // R5 specials
        run_op("R5", 64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b0, 2'b00, QN, 5'b10000);
        run_op("R5", 64'h7FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b0, 2'b00, 64'hFFF0_0000_0000_0000, 5'b00000);
        run_op("R5", 64'h7FF0_0000_0000_0123, 64'h3FF0_0000_0000_0000, 1'b0, 2'b00, QN, 5'b00000);
        run_op("R5", 64'h0000_0000_0000_0001, 64'hBFF0_0000_0000_0000, 1'b0, 2'b00, 64'h8000_0000_0000_0000, 5'b00000);
        run_op("R5", 64'h0000_0000_7F80_0000, 64'h0000_0000_8000_0000, 1'b1, 2'b00, QN, 5'b10000);
        // R6 overflow per mode
        run_op("R6", 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 2'b00, 64'h7FF0_0000_0000_0000, 5'b00101);
        run_op("R6", 64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 2'b01, 64'h7FEF_FFFF_FFFF_FFFF, 5'b00101);
        run_op("R6", 64'hFFEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 2'b10, 64'hFFEF_FFFF_FFFF_FFFF, 5'b00101);
        run_op("R6", 64'hFFEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, 1'b0, 2'b11, 64'hFFF0_0000_0000_0000, 5'b00101);
        // R7 underflow
        run_op("R7", 64'h0010_0000_0000_0000, 64'h8010_0000_0000_0000, 1'b0, 2'b00, 64'h8000_0000_0000_0000, 5'b00011);

        // R8 hold after pulse
        held = result;
        @(negedge clk);
        check("R8", "done low after pulse", {63'd0, done}, 64'd0);
        op_a = 64'h4000_0000_0000_0000;
        @(negedge clk);
        check("R8", "result held", result, held);

        // random mix, checked against the model (R1 R3 R4 R9)
        for (int i = 0; i < 600; i++) begin
            rsp = ($urandom % 3) == 0;
            rrm = 2'($urandom);
            ra  = {$urandom, $urandom};
            rb  = {$urandom, $urandom};
            if (!rsp && ($urandom % 4) != 0) begin
                ra[62:52] = 11'(900 + ($urandom % 250));
                rb[62:52] = 11'(900 + ($urandom % 250));
            end
            if (rsp && ($urandom % 4) != 0) begin
                ra[30:23] = 8'(100 + ($urandom % 60));
                rb[30:23] = 8'(100 + ($urandom % 60));
            end
            run_model(rsp ? "R1" : "R4", ra, rb, rsp, rrm);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule